// File: doc/BRIEF.md
# Accumulator Machine with Pointer-Capable Load and Store

This block is a small sequential machine built around a single accumulator. It executes a program held in a constant instruction store and works on a bounded bank of data registers whose power-on contents are set by a parameter. Arithmetic always takes the accumulator as one input and writes its result back there. The data registers are reached only by the two transfer instructions: one copies a register into the accumulator and the other copies the accumulator into a register.

Each transfer instruction carries a mode bit. In direct mode the operand field names the register. In pointer mode the operand names a register whose contents give the address of the register to use. Pointer mode is honoured only on the two transfer instructions. A read-modify-write through a pointer is therefore written as three instructions: a pointer load, an accumulator operation, and a pointer store.

A start pulse launches the program from address zero. A halted flag shows when the machine is stopped. An address outside the register bank stops the machine and raises a fault flag. A combinational debug port reads any data register at any time.

Top module: `acram_core`

## Requirements
- R1: While reset is held, and after it is released, halted is 1 and fault is 0. Every data register holds its slice of REG_INIT, with register k at bits [k*DATA_W +: DATA_W].
- R2: When the machine is halted, a start sampled high at a clock edge clears the accumulator, the program counter and fault, and drops halted after that edge. A start sampled while the machine runs has no effect.
- R3: Each direct instruction completes in one cycle. A direct LOAD (opcode 1) copies the named register into the accumulator. A direct STORE (opcode 2) writes the accumulator into the named register.
- R4: A LOAD or STORE with the mode bit set takes two cycles. The first cycle reads the register named by the operand as a pointer and leaves the program counter unchanged. The second cycle accesses the register at the pointer's value.
- R5: ADD (opcode 3) adds the named register to the accumulator modulo 2^DATA_W. SUB (opcode 4) subtracts it and gives 0 when the register is larger than the accumulator.
- R6: INC (opcode 5) adds one modulo 2^DATA_W. DEC (opcode 6) subtracts one but leaves a zero accumulator at zero. CLR (opcode 7) zeroes the accumulator. None of these three reads the data registers.
- R7: JZ (opcode 8) moves the program counter to the operand's low PC_W bits when the accumulator is zero, and to the next address otherwise. JMP (opcode 9) always moves it to the operand's low PC_W bits. The program counter wraps modulo PROG_DEPTH.
- R8: HALT (opcode 0) stops the machine and raises halted. The data registers keep their values across halts and later starts.
- R9: If the resolved register address is NREGS or greater, the machine halts with fault set and writes no register. The resolved address is the operand for direct LOAD, STORE, ADD and SUB, and the pointer value for pointer-mode LOAD and STORE.
- R10: The mode bit has no effect on any opcode other than LOAD and STORE. Opcodes 10 to 15 act as a one-cycle no-op that advances the program counter.
- R11: An instruction is OPC_W+1+OPND_W bits wide: the opcode in the top 4 bits, then the mode bit, then the operand in the low OPND_W bits. Program word k sits at PROGRAM[k*INSTR_W +: INSTR_W].
- R12: dbg_data shows, without a clock edge, the current contents of the register selected by dbg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches the program when the machine is halted |
| dbg_addr | input | $clog2(NREGS) | Register selected for debug read |
| halted | output | 1 | Machine is stopped |
| fault | output | 1 | Last run ended on an out-of-range address |
| dbg_data | output | DATA_W | Contents of the selected register |

## Verification
The bench runs one program three times. Each run takes a different path, chosen by a run counter kept in a data register, so the machine's retained state is exercised as well. The first run increments a register through a pointer. If the pointer phase were skipped, or the pointer's own register were written instead, the wrong register would change. The same run drives ADD past the top of the range and SUB below zero: a design that wraps the subtraction, or lets DEC fall to all ones, leaves a large value where 0 is expected. It also skips stores with both a taken JZ and a JMP, so a jump that falls through overwrites a register that should keep its initial value. The later runs end on a pointer fault and on a direct fault. A design that masks the address down to the bank width would write a register that must stay unchanged, and would not raise fault.

// File: rtl/acram_pkg.sv
package acram_pkg;
   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_HALT  = 4'd0,
      OP_LOAD  = 4'd1,
      OP_STORE = 4'd2,
      OP_ADD   = 4'd3,
      OP_SUB   = 4'd4,
      OP_INC   = 4'd5,
      OP_DEC   = 4'd6,
      OP_CLR   = 4'd7,
      OP_JZ    = 4'd8,
      OP_JMP   = 4'd9
   } opcode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EXEC = 2'd1,
      ST_PTR  = 2'd2
   } state_e;
endpackage

// File: rtl/acram_decode.sv
module acram_decode
   import acram_pkg::*;
#(
   parameter int OPND_W  = 8,
   parameter int INSTR_W = OPC_W + 1 + OPND_W
) (
   input  logic [INSTR_W-1:0] instr,
   output opcode_e            op,
   output logic               ind,
   output logic [OPND_W-1:0]  opnd,
   output logic               uses_reg,
   output logic               is_mem
);
   // Field layout (R11): opcode on top, mode bit, operand at the bottom
   assign op   = opcode_e'(instr[INSTR_W-1 -: OPC_W]);
   assign ind  = instr[OPND_W];
   assign opnd = instr[OPND_W-1:0];

   always_comb begin
      uses_reg = 1'b0;
      is_mem   = 1'b0;
      case (op)
         OP_LOAD, OP_STORE: begin
            uses_reg = 1'b1;
            is_mem   = 1'b1;
         end
         OP_ADD, OP_SUB: uses_reg = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/acram_alu.sv
module acram_alu
   import acram_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit SAT_SUB = 1'b1
) (
   input  opcode_e           op,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] opd,
   output logic [DATA_W-1:0] res
);
   logic [DATA_W-1:0] sub_res;

   generate
      if (SAT_SUB) begin : g_sub_floor
         assign sub_res = (opd > acc) ? '0 : acc - opd;
      end else begin : g_sub_wrap
         assign sub_res = acc - opd;
      end
   endgenerate

   always_comb begin
      case (op)
         OP_LOAD: res = opd;
         OP_ADD:  res = acc + opd;
         OP_SUB:  res = sub_res;
         OP_INC:  res = acc + DATA_W'(1);
         OP_DEC:  res = (acc == '0) ? '0 : acc - DATA_W'(1);
         OP_CLR:  res = '0;
         default: res = acc;
      endcase
   end
endmodule

// File: rtl/acram_regbank.sv
module acram_regbank #(
   parameter int                     DATA_W   = 8,
   parameter int                     NREGS    = 16,
   parameter logic [NREGS*DATA_W-1:0] REG_INIT = '0,
   parameter int                     REG_AW   = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [REG_AW-1:0] daddr,
   output logic [DATA_W-1:0] ddata
);
   logic [DATA_W-1:0] regs [NREGS];

   generate
      for (genvar k = 0; k < NREGS; k++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[k] <= REG_INIT[k*DATA_W +: DATA_W];
            else if (we && (addr == REG_AW'(k)))
               regs[k] <= wdata;
         end
      end
   endgenerate

   assign rdata = regs[addr];
   assign ddata = regs[daddr];
endmodule

// File: rtl/acram_core.sv
module acram_core
   import acram_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NREGS      = 16,
   parameter int PROG_DEPTH = 16,
   parameter int OPND_W     = 8,
   parameter bit SAT_SUB    = 1'b1,
   parameter logic [PROG_DEPTH*(OPC_W+1+OPND_W)-1:0] PROGRAM  = '0,
   parameter logic [NREGS*DATA_W-1:0]                REG_INIT = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [$clog2(NREGS)-1:0] dbg_addr,
   output logic                     halted,
   output logic                     fault,
   output logic [DATA_W-1:0]        dbg_data
);
   localparam int INSTR_W = OPC_W + 1 + OPND_W;
   localparam int REG_AW  = $clog2(NREGS);
   localparam int PC_W    = $clog2(PROG_DEPTH);
   localparam logic [OPND_W:0] LIM_OPND = (OPND_W+1)'(NREGS);
   localparam logic [DATA_W:0] LIM_PTR  = (DATA_W+1)'(NREGS);

   generate
      if (NREGS < 2)          begin : g_chk_nregs $error("NREGS must be at least 2"); end
      if (PROG_DEPTH < 2)     begin : g_chk_depth $error("PROG_DEPTH must be at least 2"); end
      if (OPND_W < REG_AW)    begin : g_chk_oreg  $error("OPND_W too narrow for a register index"); end
      if (OPND_W < PC_W)      begin : g_chk_opc   $error("OPND_W too narrow for a jump target"); end
      if (DATA_W < REG_AW)    begin : g_chk_dreg  $error("DATA_W too narrow to hold a pointer"); end
   endgenerate

   // Constant instruction store unpacked from the parameter
   logic [INSTR_W-1:0] rom [PROG_DEPTH];
   generate
      for (genvar k = 0; k < PROG_DEPTH; k++) begin : g_rom
         assign rom[k] = PROGRAM[k*INSTR_W +: INSTR_W];
      end
   endgenerate

   state_e             state_q, state_d;
   logic [PC_W-1:0]    pc_q, pc_d;
   logic [DATA_W-1:0]  acc_q, acc_d;
   logic [DATA_W-1:0]  ptr_q, ptr_d;
   logic               fault_q, fault_d;

   logic [INSTR_W-1:0] instr;
   opcode_e            op;
   logic               ind, uses_reg, is_mem;
   logic [OPND_W-1:0]  opnd;
   logic [REG_AW-1:0]  rd_addr;
   logic [DATA_W-1:0]  rd_data, alu_res;
   logic               we, dir_oor, ptr_oor;
   logic [PC_W-1:0]    jmp_tgt;

   assign instr = rom[pc_q];

   acram_decode #(.OPND_W(OPND_W), .INSTR_W(INSTR_W)) u_dec (
      .instr    (instr),
      .op       (op),
      .ind      (ind),
      .opnd     (opnd),
      .uses_reg (uses_reg),
      .is_mem   (is_mem)
   );

   assign rd_addr = (state_q == ST_PTR) ? ptr_q[REG_AW-1:0] : opnd[REG_AW-1:0];
   assign dir_oor = ({1'b0, opnd}  >= LIM_OPND);
   assign ptr_oor = ({1'b0, ptr_q} >= LIM_PTR);
   assign jmp_tgt = opnd[PC_W-1:0];

   acram_regbank #(
      .DATA_W   (DATA_W),
      .NREGS    (NREGS),
      .REG_INIT (REG_INIT),
      .REG_AW   (REG_AW)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .addr  (rd_addr),
      .wdata (acc_q),
      .rdata (rd_data),
      .daddr (dbg_addr),
      .ddata (dbg_data)
   );

   acram_alu #(.DATA_W(DATA_W), .SAT_SUB(SAT_SUB)) u_alu (
      .op  (op),
      .acc (acc_q),
      .opd (rd_data),
      .res (alu_res)
   );

   always_comb begin
      state_d = state_q;
      pc_d    = pc_q;
      acc_d   = acc_q;
      ptr_d   = ptr_q;
      fault_d = fault_q;
      we      = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_d = ST_EXEC;
               pc_d    = '0;
               acc_d   = '0;
               fault_d = 1'b0;
            end
         end
         ST_EXEC: begin
            if (op == OP_HALT) begin
               state_d = ST_IDLE;
            end else if (uses_reg && dir_oor) begin
               state_d = ST_IDLE;
               fault_d = 1'b1;
            end else if (is_mem && ind) begin
               ptr_d   = rd_data;
               state_d = ST_PTR;
            end else begin
               pc_d = pc_q + PC_W'(1);
               case (op)
                  OP_STORE: we = 1'b1;
                  OP_JZ:    if (acc_q == '0) pc_d = jmp_tgt;
                  OP_JMP:   pc_d = jmp_tgt;
                  default:  acc_d = alu_res;
               endcase
            end
         end
         ST_PTR: begin
            if (ptr_oor) begin
               state_d = ST_IDLE;
               fault_d = 1'b1;
            end else begin
               state_d = ST_EXEC;
               pc_d    = pc_q + PC_W'(1);
               if (op == OP_STORE) we = 1'b1;
               else                acc_d = alu_res;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
         acc_q   <= '0;
         ptr_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         state_q <= state_d;
         pc_q    <= pc_d;
         acc_q   <= acc_d;
         ptr_q   <= ptr_d;
         fault_q <= fault_d;
      end
   end

   assign halted = (state_q == ST_IDLE);
   assign fault  = fault_q;
endmodule

// File: rtl/acram_chk.sv
module acram_chk
   import acram_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PC_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              halted,
   input logic              fault,
   input state_e            state_q,
   input logic [PC_W-1:0]   pc_q,
   input logic [PC_W-1:0]   jmp_tgt,
   input logic [DATA_W-1:0] acc_q,
   input logic [DATA_W-1:0] rd_data,
   input opcode_e           op,
   input logic              dir_oor
);
   AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && start) |=> !halted);                                        // R2
   AST_START_CLEARS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && start) |=> !fault);                                         // R2
   AST_PTR_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PTR) |-> ($past(state_q) == ST_EXEC));                  // R4
   AST_PTR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PTR) |=> (state_q != ST_PTR));                          // R4
   AST_PTR_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PTR) |-> $stable(pc_q));                                // R4
   AST_SUB_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXEC && op == OP_SUB && !dir_oor && rd_data > acc_q)
      |=> (acc_q == '0));                                                    // R5
   AST_DEC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXEC && op == OP_DEC && acc_q == '0) |=> (acc_q == '0)); // R6
   AST_JMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXEC && op == OP_JMP) |=> (pc_q == $past(jmp_tgt)));    // R7
   AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> halted);                                                     // R9
endmodule

bind acram_core acram_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .halted  (halted),
   .fault   (fault),
   .state_q (state_q),
   .pc_q    (pc_q),
   .jmp_tgt (jmp_tgt),
   .acc_q   (acc_q),
   .rd_data (rd_data),
   .op      (op),
   .dir_oor (dir_oor)
);

// File: tb/sim_acram_core.sv
module sim_acram_core;
   localparam int DW = 8;
   localparam int NR = 16;
   localparam int PD = 64;
   localparam int OW = 8;
   localparam int IW = 4 + 1 + OW;

   localparam int HLT = 0, LDA = 1, STA = 2, ADD = 3, SUB = 4, INC = 5,
                  DEC = 6, CLR = 7, JZ = 8, JMP = 9, NOPX = 12;

   // R11: {opcode[3:0], mode, operand[OW-1:0]}
   function automatic logic [IW-1:0] enc(input int op, input bit ind, input int opnd);
      return {4'(op), ind, 8'(opnd)};
   endfunction

   function automatic logic [PD*IW-1:0] build_prog();
      logic [PD*IW-1:0] p;
      p = '0;
      p[ 0*IW +: IW] = enc(LDA, 0, 15);
      p[ 1*IW +: IW] = enc(JZ,  0, 10);
      p[ 2*IW +: IW] = enc(DEC, 0, 0);
      p[ 3*IW +: IW] = enc(JZ,  0, 6);
      p[ 4*IW +: IW] = enc(STA, 0, 40);   // direct out of range
      p[ 5*IW +: IW] = enc(HLT, 0, 0);
      p[ 6*IW +: IW] = enc(INC, 0, 0);
      p[ 7*IW +: IW] = enc(INC, 0, 0);
      p[ 8*IW +: IW] = enc(STA, 0, 15);
      p[ 9*IW +: IW] = enc(LDA, 1, 5);    // pointer 20: out of range
      p[10*IW +: IW] = enc(INC, 0, 0);
      p[11*IW +: IW] = enc(STA, 0, 15);
      p[12*IW +: IW] = enc(LDA, 1, 2);
      p[13*IW +: IW] = enc(INC, 0, 0);
      p[14*IW +: IW] = enc(STA, 1, 2);
      p[15*IW +: IW] = enc(LDA, 0, 3);
      p[16*IW +: IW] = enc(ADD, 0, 4);
      p[17*IW +: IW] = enc(STA, 0, 10);
      p[18*IW +: IW] = enc(SUB, 0, 3);
      p[19*IW +: IW] = enc(DEC, 0, 0);
      p[20*IW +: IW] = enc(STA, 0, 11);
      p[21*IW +: IW] = enc(LDA, 0, 6);
      p[22*IW +: IW] = enc(INC, 0, 0);
      p[23*IW +: IW] = enc(JZ,  0, 25);
      p[24*IW +: IW] = enc(STA, 0, 12);
      p[25*IW +: IW] = enc(LDA, 0, 4);
      p[26*IW +: IW] = enc(SUB, 0, 1);
      p[27*IW +: IW] = enc(JZ,  0, 0);
      p[28*IW +: IW] = enc(DEC, 1, 0);
      p[29*IW +: IW] = enc(NOPX, 1, 13);
      p[30*IW +: IW] = enc(STA, 0, 13);
      p[31*IW +: IW] = enc(CLR, 0, 0);
      p[32*IW +: IW] = enc(JMP, 0, 34);
      p[33*IW +: IW] = enc(STA, 0, 14);
      p[34*IW +: IW] = enc(ADD, 0, 1);
      p[35*IW +: IW] = enc(STA, 0, 7);
      p[36*IW +: IW] = enc(HLT, 0, 0);
      return p;
   endfunction

   function automatic logic [NR*DW-1:0] build_init();
      logic [NR*DW-1:0] v;
      v = '0;
      v[ 1*DW +: DW] = 8'd5;
      v[ 2*DW +: DW] = 8'd9;
      v[ 3*DW +: DW] = 8'd200;
      v[ 4*DW +: DW] = 8'd100;
      v[ 5*DW +: DW] = 8'd20;
      v[ 6*DW +: DW] = 8'd255;
      v[ 9*DW +: DW] = 8'd17;
      v[11*DW +: DW] = 8'd7;
      v[12*DW +: DW] = 8'd3;
      v[14*DW +: DW] = 8'd6;
      return v;
   endfunction

   localparam logic [PD*IW-1:0] PROG = build_prog();
   localparam logic [NR*DW-1:0] INIT = build_init();

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [3:0]    dbg_addr = '0;
   logic          halted, fault;
   logic [DW-1:0] dbg_data;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   acram_core #(
      .DATA_W(DW), .NREGS(NR), .PROG_DEPTH(PD), .OPND_W(OW),
      .PROGRAM(PROG), .REG_INIT(INIT)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .dbg_addr(dbg_addr),
      .halted(halted), .fault(fault), .dbg_data(dbg_data)
   );

   // Behavioural reference model
   bit m_run, m_fault, m_ptrph;
   int m_pc, m_acc, m_ptr;
   int m_regs [NR];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_fault = 0; m_ptrph = 0;
         m_pc = 0; m_acc = 0; m_ptr = 0;
         for (int k = 0; k < NR; k++) m_regs[k] = int'(INIT[k*DW +: DW]);
      end else if (!m_run) begin
         if (start) begin
            m_run = 1; m_pc = 0; m_acc = 0; m_fault = 0; m_ptrph = 0;
         end
      end else begin
         logic [IW-1:0] ins;
         int op, opnd;
         bit ind;
         ins  = PROG[m_pc*IW +: IW];
         op   = int'(ins[IW-1 -: 4]);
         ind  = ins[OW];
         opnd = int'(ins[OW-1:0]);
         if (m_ptrph) begin
            m_ptrph = 0;
            if (m_ptr >= NR) begin m_run = 0; m_fault = 1; end
            else begin
               if (op == LDA) m_acc = m_regs[m_ptr];
               else           m_regs[m_ptr] = m_acc;
               m_pc = (m_pc + 1) % PD;
            end
         end else if (op == HLT) begin
            m_run = 0;
         end else if ((op == LDA || op == STA || op == ADD || op == SUB) && opnd >= NR) begin
            m_run = 0; m_fault = 1;
         end else if ((op == LDA || op == STA) && ind) begin
            m_ptr = m_regs[opnd]; m_ptrph = 1;
         end else begin
            m_pc = (m_pc + 1) % PD;
            case (op)
               LDA: m_acc = m_regs[opnd];
               STA: m_regs[opnd] = m_acc;
               ADD: m_acc = (m_acc + m_regs[opnd]) % 256;
               SUB: m_acc = (m_regs[opnd] > m_acc) ? 0 : m_acc - m_regs[opnd];
               INC: m_acc = (m_acc + 1) % 256;
               DEC: m_acc = (m_acc == 0) ? 0 : m_acc - 1;
               CLR: m_acc = 0;
               JZ:  if (m_acc == 0) m_pc = opnd % PD;
               JMP: m_pc = opnd % PD;
               default: ;
            endcase
         end
      end
   end

   // Per-clock comparison against the model (R3 R4 R8 R12)
   always @(negedge clk) begin
      n_cmp++;
      if (halted !== !m_run || fault !== m_fault || int'(dbg_data) != m_regs[dbg_addr]) begin
         n_bad++;
         $display("FAIL R3/R4/R12 cycle-model t=%0t: halted/fault/dbg[%0d] act %b %b %0d exp %b %b %0d",
                  $time, dbg_addr, halted, fault, dbg_data, !m_run, m_fault, m_regs[dbg_addr]);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: act %0d exp %0d", tag, act, exp);
      end
   endtask

   task automatic chk_reg(input int a, input int exp, input string tag);
      @(posedge clk); #1 dbg_addr = 4'(a);
      @(negedge clk);
      chk(tag, int'(dbg_data), exp);
   endtask

   task automatic run(input int poke_at);
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      @(negedge clk);
      chk("R2 halted drops after start", int'(halted), 0);
      for (int c = 0; c < 500 && m_run; c++) begin
         @(posedge clk); #1;
         dbg_addr = dbg_addr + 4'd1;
         start = (c == poke_at);   // R2: start while running is ignored
      end
      start = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: act running exp finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 halted in reset", int'(halted), 1);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 halted after reset", int'(halted), 1);
      chk("R1 fault after reset", int'(fault), 0);
      chk_reg(1, 5, "R1 init r1");
      chk_reg(6, 255, "R1 init r6");

      run(5);
      chk("R8 halted after HALT", int'(halted), 1);
      chk("R8 no fault", int'(fault), 0);
      chk_reg(15, 1, "R3 direct store r15");
      chk_reg(9, 18, "R4 pointer increment r9");
      chk_reg(2, 9, "R4 pointer register kept");
      chk_reg(10, 44, "R5 ADD wraps");
      chk_reg(11, 0, "R5 SUB floor and R6 DEC floor");
      chk_reg(12, 3, "R7 JZ taken skips store");
      chk_reg(14, 6, "R7 JMP skips store");
      chk_reg(13, 94, "R10 mode bit and no-op ignored");
      chk_reg(7, 5, "R6 CLR then ADD");

      run(-1);
      chk("R9 pointer fault", int'(fault), 1);
      chk("R9 halted on fault", int'(halted), 1);
      chk_reg(15, 2, "R8 registers kept across runs");

      run(-1);
      chk("R9 direct fault", int'(fault), 1);
      chk_reg(8, 0, "R9 no write on out-of-range store");

      repeat (4) @(posedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule